// File: doc/BRIEF.md
# Weighted Associative Bit Matcher

This block holds a small database of binary patterns and a bank of per-bit-position weights. Every query pattern is compared bit by bit against all stored entries at once. Each entry's figure of merit starts at zero for the query. Where the query bit equals the stored bit in the same position, that position's weight is added. Where the two bits differ, the weight is subtracted. The block returns the entry with the highest figure of merit together with that signed score.

Patterns and weights are written through one load port. A select bit chooses whether the address names a database entry or a bit position. Queries use a valid/ready handshake. While a load is being presented, ready is low and no query is accepted. The result is registered and appears one cycle after the query is accepted. It stays on the outputs until the next result replaces it.

Top module: `wbm_top`

## Requirements
- R1: After reset, res_valid is 0 and every stored pattern and every weight is zero, so the first query returns index 0 with score 0.
- R2: When ld_valid is 1 and ld_sel is 0, ld_data is written into database entry ld_addr. An address at or above the entry count is ignored.
- R3: When ld_valid is 1 and ld_sel is 1, ld_data[3:0] becomes the unsigned weight of bit position ld_addr.
- R4: For each entry the score is zero plus, for every bit position i, weight[i] when q_data[i] equals the stored bit i and minus weight[i] when they differ.
- R5: All entries are scored for every query. res_idx names the entry with the highest score and res_score carries that score as two's complement.
- R6: When several entries share the highest score, res_idx is the lowest of their indices.
- R7: res_valid is 1 in exactly the cycle after a clock edge at which q_valid and q_ready were both 1, and 0 otherwise.
- R8: q_ready is 0 whenever ld_valid is 1. A query offered in that cycle is not accepted, and the load still takes effect.
- R9: res_score represents the full range from minus to plus 32 times 15 without overflow, including both extremes of 480 and -480.
- R10: res_idx and res_score keep their values in every cycle that follows a clock edge with no accepted query.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Load request for this cycle |
| ld_sel | input | 1 | 0: write a database entry, 1: write a bit weight |
| ld_addr | input | 5 | Entry index or bit position |
| ld_data | input | 32 | Pattern, or weight in bits 3:0 |
| q_valid | input | 1 | Query offered |
| q_ready | output | 1 | Query can be accepted (low during a load) |
| q_data | input | 32 | Query pattern |
| res_valid | output | 1 | Result present, one cycle after acceptance |
| res_idx | output | 3 | Index of the best-scoring entry |
| res_score | output | 10 | Signed figure of merit of that entry |

## Verification
The hardest situation to reach is a tie for the top score between entries that are not adjacent. It needs deliberately equal patterns, or weights arranged so that different disagreement sets cost the same amount. The stimulus produces ties in both ways. It writes identical patterns into two non-neighbouring entries and fills the rest with their complement. It also zeroes every weight so that all eight entries tie. The score extremes of plus and minus 480 are reached by setting every weight to 15 and querying a stored pattern and then its inverse. Between these cases, a long pseudo-random sweep of queries is checked against an arithmetic model.

// File: rtl/wbm_pkg.sv
package wbm_pkg;
  // Select values on the load port
  typedef enum logic {
    LD_PATTERN = 1'b0,
    LD_WEIGHT  = 1'b1
  } ld_kind_e;

  // Largest magnitude a score can take
  function automatic int max_score(input int pat_w, input int wgt_w);
    return pat_w * ((1 << wgt_w) - 1);
  endfunction
endpackage

// File: rtl/wbm_store.sv
module wbm_store #(
  parameter int PAT_W   = 32,
  parameter int ENTRIES = 8,
  parameter int WGT_W   = 4,
  parameter int AW      = 5
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic                              wr_sel,
  input  logic [AW-1:0]                     wr_addr,
  input  logic [PAT_W-1:0]                  wr_data,
  output logic [ENTRIES-1:0][PAT_W-1:0]     pat_q,
  output logic [PAT_W-1:0][WGT_W-1:0]       wgt_q
);
  import wbm_pkg::*;

  ld_kind_e kind;
  assign kind = ld_kind_e'(wr_sel);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_pat
    always_ff @(posedge clk) begin
      if (rst)
        pat_q[e] <= '0;
      else if (wr_en && kind == LD_PATTERN && wr_addr == AW'(e))
        pat_q[e] <= wr_data;
    end
  end

  for (genvar b = 0; b < PAT_W; b++) begin : g_wgt
    always_ff @(posedge clk) begin
      if (rst)
        wgt_q[b] <= '0;
      else if (wr_en && kind == LD_WEIGHT && wr_addr == AW'(b))
        wgt_q[b] <= wr_data[WGT_W-1:0];
    end
  end
endmodule

// File: rtl/wbm_scorer.sv
module wbm_scorer #(
  parameter int PAT_W = 32,
  parameter int WGT_W = 4,
  parameter int SW    = 10
) (
  input  logic [PAT_W-1:0]            query,
  input  logic [PAT_W-1:0]            pattern,
  input  logic [PAT_W-1:0][WGT_W-1:0] weights,
  output logic signed [SW-1:0]        score
);
  logic signed [SW-1:0] acc;
  logic signed [SW-1:0] term;

  always_comb begin
    acc  = '0;
    term = '0;
    for (int i = 0; i < PAT_W; i++) begin
      term = SW'(weights[i]);
      if (query[i] == pattern[i])
        acc = acc + term;
      else
        acc = acc - term;
    end
    score = acc;
  end
endmodule

// File: rtl/wbm_argmax.sv
module wbm_argmax #(
  parameter int ENTRIES = 8,
  parameter int SW      = 10,
  parameter int IW      = 3
) (
  input  logic [ENTRIES-1:0][SW-1:0] scores,
  output logic [IW-1:0]              best_idx,
  output logic signed [SW-1:0]       best_score
);
  always_comb begin
    best_idx   = '0;
    best_score = $signed(scores[0]);
    // strict comparison keeps the earliest entry on equal scores
    for (int e = 1; e < ENTRIES; e++) begin
      if ($signed(scores[e]) > best_score) begin
        best_score = $signed(scores[e]);
        best_idx   = IW'(e);
      end
    end
  end
endmodule

// File: rtl/wbm_top.sv
module wbm_top #(
  parameter int PAT_W   = 32,
  parameter int ENTRIES = 8,
  parameter int WGT_W   = 4,
  localparam int MAXS   = PAT_W * ((1 << WGT_W) - 1),
  localparam int SW     = $clog2(MAXS + 1) + 1,
  localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int AMAX   = (PAT_W > ENTRIES) ? PAT_W : ENTRIES,
  localparam int AW     = (AMAX > 1) ? $clog2(AMAX) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ld_valid,
  input  logic                     ld_sel,
  input  logic [AW-1:0]            ld_addr,
  input  logic [PAT_W-1:0]         ld_data,
  input  logic                     q_valid,
  output logic                     q_ready,
  input  logic [PAT_W-1:0]         q_data,
  output logic                     res_valid,
  output logic [IW-1:0]            res_idx,
  output logic signed [SW-1:0]     res_score
);
  logic [ENTRIES-1:0][PAT_W-1:0] pat_q;
  logic [PAT_W-1:0][WGT_W-1:0]   wgt_q;
  logic [ENTRIES-1:0][SW-1:0]    scores;
  logic [IW-1:0]                 best_idx;
  logic signed [SW-1:0]          best_score;
  logic                          accept;

  assign q_ready = ~ld_valid;
  assign accept  = q_valid & q_ready;

  wbm_store #(.PAT_W(PAT_W), .ENTRIES(ENTRIES), .WGT_W(WGT_W), .AW(AW)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (ld_valid),
    .wr_sel  (ld_sel),
    .wr_addr (ld_addr),
    .wr_data (ld_data),
    .pat_q   (pat_q),
    .wgt_q   (wgt_q)
  );

  for (genvar e = 0; e < ENTRIES; e++) begin : g_score
    logic signed [SW-1:0] s;
    wbm_scorer #(.PAT_W(PAT_W), .WGT_W(WGT_W), .SW(SW)) u_scorer (
      .query   (q_data),
      .pattern (pat_q[e]),
      .weights (wgt_q),
      .score   (s)
    );
    assign scores[e] = s;
  end

  wbm_argmax #(.ENTRIES(ENTRIES), .SW(SW), .IW(IW)) u_argmax (
    .scores     (scores),
    .best_idx   (best_idx),
    .best_score (best_score)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_idx   <= '0;
      res_score <= '0;
    end else begin
      res_valid <= accept;
      if (accept) begin
        res_idx   <= best_idx;
        res_score <= best_score;
      end
    end
  end
endmodule

// File: rtl/wbm_checks.sv
module wbm_checks #(
  parameter int PAT_W   = 32,
  parameter int ENTRIES = 8,
  parameter int WGT_W   = 4,
  parameter int SW      = 10,
  parameter int IW      = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 ld_valid,
  input logic                 q_valid,
  input logic                 q_ready,
  input logic                 res_valid,
  input logic [IW-1:0]        res_idx,
  input logic signed [SW-1:0] res_score
);
  localparam int MAXS = wbm_pkg::max_score(PAT_W, WGT_W);

  p_result_after_accept_r7: assert property (@(posedge clk) disable iff (rst)
    (q_valid && q_ready) |=> res_valid);

  p_no_spurious_result_r7: assert property (@(posedge clk) disable iff (rst)
    !(q_valid && q_ready) |=> !res_valid);

  p_ready_low_on_load_r8: assert property (@(posedge clk) disable iff (rst)
    ld_valid |-> !q_ready);

  p_result_held_r10: assert property (@(posedge clk) disable iff (rst)
    !(q_valid && q_ready) |=> ($stable(res_idx) && $stable(res_score)));

  p_score_in_range_r9: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (int'(res_score) <= MAXS && int'(res_score) >= -MAXS));

  p_index_in_range_r5: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (int'(res_idx) < ENTRIES));
endmodule

bind wbm_top wbm_checks #(
  .PAT_W(PAT_W), .ENTRIES(ENTRIES), .WGT_W(WGT_W), .SW(SW), .IW(IW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ld_valid  (ld_valid),
  .q_valid   (q_valid),
  .q_ready   (q_ready),
  .res_valid (res_valid),
  .res_idx   (res_idx),
  .res_score (res_score)
);

// File: tb/sim_wbm_top.sv
`timescale 1ns/1ps
module sim_wbm_top;
  localparam int PAT_W = 32;
  localparam int ENT   = 8;
  localparam int SW    = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_valid = 1'b0, ld_sel = 1'b0;
  logic [4:0] ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic q_valid = 1'b0;
  logic q_ready;
  logic [31:0] q_data = '0;
  logic res_valid;
  logic [2:0] res_idx;
  logic signed [SW-1:0] res_score;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] m_pat [ENT];
  int m_wgt [PAT_W];
  logic [31:0] rng = 32'h1234_5678;

  always #2 clk = ~clk;

  wbm_top u0 (.clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_sel(ld_sel),
    .ld_addr(ld_addr), .ld_data(ld_data), .q_valid(q_valid), .q_ready(q_ready),
    .q_data(q_data), .res_valid(res_valid), .res_idx(res_idx), .res_score(res_score));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return rng;
  endfunction

  function automatic int model_score(input int e, input logic [31:0] q);
    int s = 0;
    for (int i = 0; i < PAT_W; i++)
      s += (q[i] == m_pat[e][i]) ? m_wgt[i] : -m_wgt[i];
    return s;
  endfunction

  task automatic load(input bit sel, input int addr, input logic [31:0] d);
    @(negedge clk);
    ld_valid = 1'b1; ld_sel = sel; ld_addr = 5'(addr); ld_data = d;
    @(posedge clk);
    @(negedge clk);
    ld_valid = 1'b0;
    if (sel) m_wgt[addr] = int'(d[3:0]);
    else if (addr < ENT) m_pat[addr] = d;
  endtask

  task automatic query(input logic [31:0] q, input string tag);
    int best, bi, s;
    @(negedge clk);
    q_valid = 1'b1; q_data = q;
    @(posedge clk);
    @(negedge clk);
    q_valid = 1'b0;
    best = model_score(0, q); bi = 0;
    for (int e = 1; e < ENT; e++) begin
      s = model_score(e, q);
      if (s > best) begin best = s; bi = e; end
    end
    chk(res_valid === 1'b1, {tag, " R7 valid"}, int'(res_valid), 1);
    chk(int'(res_idx) == bi, {tag, " R5 index"}, int'(res_idx), bi);
    chk(int'(res_score) == best, {tag, " R4 score"}, int'(res_score), best);
  endtask

  initial begin
    #(4ns * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] p;
    for (int e = 0; e < ENT; e++) m_pat[e] = '0;
    for (int i = 0; i < PAT_W; i++) m_wgt[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(res_valid === 1'b0, "R1 res_valid after reset", int'(res_valid), 0);
    chk(q_ready === 1'b1, "R1 q_ready idle", int'(q_ready), 1);
    query(32'hDEAD_BEEF, "R1 zero db");
    // R6: all weights zero -> all entries tie at 0
    p = nxt();
    for (int e = 0; e < ENT; e++) load(1'b0, e, nxt());
    query(p, "R6 all tie");
    chk(int'(res_idx) == 0, "R6 all-tie lowest index", int'(res_idx), 0);

    // R3 weights, R2 patterns, then sweep
    for (int i = 0; i < PAT_W; i++) load(1'b1, i, 32'((i * 7 + 3) % 16));
    for (int e = 0; e < ENT; e++) load(1'b0, e, nxt());
    load(1'b0, 9, 32'hFFFF_FFFF); // R2 out-of-range address ignored
    for (int k = 0; k < 300; k++) begin
      if (k % 5 == 0) p = m_pat[k % ENT] ^ (32'h1 << (k % 32));
      else p = nxt();
      query(p, "R2 R3 sweep");
    end
    // R3: reweight a few positions, recheck
    for (int k = 0; k < 40; k++) begin
      load(1'b1, int'(nxt() % 32), nxt());
      query(nxt(), "R3 reweight");
    end

    // R6: ties between entries 3 and 6
    p = nxt();
    for (int e = 0; e < ENT; e++) load(1'b0, e, ~p);
    load(1'b0, 3, p);
    load(1'b0, 6, p);
    query(p, "R6 tie pair");
    chk(int'(res_idx) == 3, "R6 tie lowest", int'(res_idx), 3);

    // R9: extremes
    for (int i = 0; i < PAT_W; i++) load(1'b1, i, 32'hF);
    query(p, "R9 max");
    chk(int'(res_score) == 480, "R9 max score", int'(res_score), 480);
    for (int e = 0; e < ENT; e++) load(1'b0, e, p);
    query(~p, "R9 min");
    chk(int'(res_score) == -480, "R9 min score", int'(res_score), -480);
    chk(int'(res_idx) == 0, "R9 min index", int'(res_idx), 0);

    // R10: hold while idle
    repeat (4) begin
      @(negedge clk);
      chk(res_valid === 1'b0, "R7 idle no result", int'(res_valid), 0);
      chk(int'(res_score) == -480, "R10 score held", int'(res_score), -480);
      chk(int'(res_idx) == 0, "R10 index held", int'(res_idx), 0);
    end

    // R8: query during load is refused, load still lands
    @(negedge clk);
    ld_valid = 1'b1; ld_sel = 1'b0; ld_addr = 5'd5; ld_data = ~p;
    q_valid = 1'b1; q_data = ~p;
    #1;
    chk(q_ready === 1'b0, "R8 ready low during load", int'(q_ready), 0);
    @(posedge clk);
    @(negedge clk);
    ld_valid = 1'b0; q_valid = 1'b0;
    m_pat[5] = ~p;
    chk(res_valid === 1'b0, "R8 query not accepted", int'(res_valid), 0);
    chk(int'(res_score) == -480, "R8 R10 score unchanged", int'(res_score), -480);
    query(~p, "R8 load landed");
    chk(int'(res_idx) == 5, "R8 loaded entry wins", int'(res_idx), 5);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule